// File: doc/BRIEF.md
# Privileged Interrupt Status Controller

This block gathers single-cycle event pulses from a parameterised set of hardware sources, 49 by default, and holds each one in a sticky status bit until software clears it. Software reaches the block through a plain register bus: a write strobe, a word address, a write data word, a privilege qualifier, and combinational read data. Per source it keeps an enable (mask) bit, an IRQ-route bit, an NMI-route bit and a protection bit. Software can also set a status bit on purpose through a write-1-to-set preset control, and reset one through a write-1-to-clear control.

Two combined interrupt lines leave the block. The maskable line respects the enable bits. The non-maskable line ignores them. The raw triggers are also passed straight out, so an outside interrupt controller can take the events directly. When a source's protection bit is set, only privileged writes may preset or clear its status. The routing and protection registers accept privileged writes only.

Top module: `priv_irq_ctrl`

## Requirements
- R1: A synchronous active-low reset sets every register to zero. While reset is held and after it, every readable word returns 0 and irq_o and nmi_o stay low.
- R2: An event pulse on hw_evt_i[i] makes status bit i read as 1 from the next cycle on. The bit stays at 1 until a clear is accepted for it.
- R3: A write of 1 to a bit of the preset register (register id 2) sets the matching status bit on the next cycle. A write of 0 to a preset bit leaves the status bit unchanged.
- R4: A write of 1 to a bit of the clear register (register id 3) resets the matching status bit on the next cycle, provided no event arrives for that source in the same cycle. A write of 0 to a clear bit leaves the status bit unchanged.
- R5: If an event on source i and an accepted clear of source i fall in the same cycle, status bit i remains 1.
- R6: irq_o is high exactly when some source has status, enable (register id 0) and IRQ-route (register id 4) all set.
- R7: nmi_o is high exactly when some source has status and NMI-route (register id 5) both set, whatever its enable bit holds.
- R8: raw_trig_o equals hw_evt_i in the same cycle, with no mask applied.
- R9: If protection bit i (register id 6) is set, a preset or clear write with bus_priv_i low leaves status bit i unchanged. The same write with bus_priv_i high takes effect.
- R10: Writes to the IRQ-route, NMI-route and protection registers are ignored when bus_priv_i is low. The enable register accepts writes at either privilege level.
- R11: The address is {register id[2:0], word}. Word 0 holds sources 0 to 31 and word 1 holds sources 32 to 48 in bits 0 to 16. Status (id 1) is read-only, and writes to it are ignored. Preset, clear, id 7, and bits above source 48 all read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe, one write per cycle |
| bus_priv_i | input | 1 | High for a privileged access |
| bus_addr_i | input | 4 | Word address {register id, word} |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| hw_evt_i | input | 49 | Single-cycle event pulses, one per source |
| raw_trig_o | output | 49 | Unmasked copy of the event pulses |
| irq_o | output | 1 | Combined maskable interrupt |
| nmi_o | output | 1 | Combined non-maskable interrupt |

## Verification
The hardware event path and a software clear can act on the same status bit in one clock cycle. The bench provokes this by raising the event pulse of one source on the same falling edge that it places a privileged clear of that source on the bus, so both are taken on the next rising edge. It then reads the status word back and expects the bit still set. It follows with a clear on its own, with no event, and expects the bit to drop, which shows that the clear path works and that the event alone is why the bit survived.

// File: rtl/pic_pkg.sv
// Package: shared register identifiers for the interrupt status controller.
// Assumes the bus address carries the register id in its upper three bits.
package pic_pkg;
    typedef enum logic [2:0] {
        REG_ENABLE  = 3'd0,
        REG_STATUS  = 3'd1,
        REG_PRESET  = 3'd2,
        REG_CLEAR   = 3'd3,
        REG_IRQSEL  = 3'd4,
        REG_NMISEL  = 3'd5,
        REG_PROTECT = 3'd6,
        REG_NONE    = 3'd7
    } pic_reg_e;
endpackage

// File: rtl/pic_bus_decode.sv
// Module: pic_bus_decode
// Splits a word address into register id and word index. Produces one write
// strobe per writable register, and spreads the data word onto per-source
// lanes with a mask marking the sources held in the addressed word.
// Assumes at most one write per cycle and WSEL_W bits of word index.
module pic_bus_decode
    import pic_pkg::*;
#(
    parameter int NUM_SRC = 49,
    parameter int DATA_W  = 32,
    parameter int WSEL_W  = 1,
    localparam int ADDR_W = 3 + WSEL_W
) (
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output pic_reg_e          reg_id_o,
    output logic [WSEL_W-1:0] word_o,
    output logic              wr_enable_o,
    output logic              wr_preset_o,
    output logic              wr_clear_o,
    output logic              wr_irqsel_o,
    output logic              wr_nmisel_o,
    output logic              wr_protect_o,
    output logic [NUM_SRC-1:0] lane_mask_o,
    output logic [NUM_SRC-1:0] lane_data_o
);
    // Field split of the address.
    always_comb begin
        reg_id_o = pic_reg_e'(addr_i[ADDR_W-1:WSEL_W]);
        word_o   = addr_i[WSEL_W-1:0];
    end

    // Write strobes, one per writable register; status and id 7 get none.
    always_comb begin
        wr_enable_o  = wr_i && (reg_id_o == REG_ENABLE);
        wr_preset_o  = wr_i && (reg_id_o == REG_PRESET);
        wr_clear_o   = wr_i && (reg_id_o == REG_CLEAR);
        wr_irqsel_o  = wr_i && (reg_id_o == REG_IRQSEL);
        wr_nmisel_o  = wr_i && (reg_id_o == REG_NMISEL);
        wr_protect_o = wr_i && (reg_id_o == REG_PROTECT);
    end

    // Per-source lane: which word a source lives in and its data bit.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
        localparam int WIDX = i / DATA_W;
        localparam int BIDX = i % DATA_W;
        assign lane_mask_o[i] = (int'(word_o) == WIDX);
        assign lane_data_o[i] = wdata_i[BIDX];
    end
endmodule

// File: rtl/pic_mask_reg.sv
// Module: pic_mask_reg
// One per-source configuration register (enable, routing or protection).
// The addressed word's lanes are overwritten on an accepted write. With
// PRIV_ONLY set, writes without the privilege qualifier are dropped.
// Assumes lane mask and data come from pic_bus_decode.
module pic_mask_reg #(
    parameter int NUM_SRC   = 49,
    parameter bit PRIV_ONLY = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_hit_i,
    input  logic               priv_i,
    input  logic [NUM_SRC-1:0] lane_mask_i,
    input  logic [NUM_SRC-1:0] lane_data_i,
    output logic [NUM_SRC-1:0] q_o
);
    logic accept;

    // Privilege gate for the write.
    always_comb accept = wr_hit_i && (!PRIV_ONLY || priv_i);

    // Register update of the addressed lanes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= '0;
        else if (accept)
            q_o <= (q_o & ~lane_mask_i) | (lane_data_i & lane_mask_i);
    end

    AST_CFG_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> (q_o == '0)); // R1

    if (PRIV_ONLY) begin : g_lock_chk
        AST_USER_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_hit_i && !priv_i) |=> $stable(q_o)); // R10
    end
endmodule

// File: rtl/pic_status_bank.sv
// Module: pic_status_bank
// Sticky per-source status bits. An event sets its bit; an accepted preset
// sets and an accepted clear resets. The event beats a clear in the same
// cycle, and a preset beats a clear. A protected bit accepts preset and
// clear only from privileged writes.
// Assumes events are single-cycle pulses synchronous to clk.
module pic_status_bank #(
    parameter int NUM_SRC = 49
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               set_i,
    input  logic               clr_i,
    input  logic               priv_i,
    input  logic [NUM_SRC-1:0] lane_mask_i,
    input  logic [NUM_SRC-1:0] lane_data_i,
    input  logic [NUM_SRC-1:0] protect_i,
    output logic [NUM_SRC-1:0] status_o
);
    logic [NUM_SRC-1:0] allowed;
    logic [NUM_SRC-1:0] set_eff;
    logic [NUM_SRC-1:0] clr_eff;
    logic [NUM_SRC-1:0] status_nxt;

    // Which sources this access may touch.
    always_comb allowed = ~protect_i | {NUM_SRC{priv_i}};

    // Effective set and clear vectors from the addressed lanes.
    always_comb begin
        set_eff = {NUM_SRC{set_i}} & lane_mask_i & lane_data_i & allowed;
        clr_eff = {NUM_SRC{clr_i}} & lane_mask_i & lane_data_i & allowed;
    end

    // Next status: events and presets dominate clears.
    always_comb status_nxt = evt_i | set_eff | (status_o & ~clr_eff);

    // Status register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_o <= '0;
        else
            status_o <= status_nxt;
    end

    AST_STATUS_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> (status_o == '0)); // R1

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit_chk
        AST_EVT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[i] |=> status_o[i]); // R5
        AST_HOLD_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (status_o[i] && !clr_i) |=> status_o[i]); // R2
        AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (!status_o[i] && !evt_i[i] && !set_i) |=> !status_o[i]); // R3
        AST_PROT_USER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !priv_i && protect_i[i] && status_o[i]) |=> status_o[i]); // R9
    end
endmodule

// File: rtl/pic_irq_merge.sv
// Module: pic_irq_merge
// Reduces the per-source state to the two combined interrupt lines. The
// maskable line needs status, enable and IRQ route; the non-maskable line
// needs status and NMI route only.
// Assumes all inputs are registered state, so outputs are glitch-limited.
module pic_irq_merge #(
    parameter int NUM_SRC = 49
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] status_i,
    input  logic [NUM_SRC-1:0] enable_i,
    input  logic [NUM_SRC-1:0] irq_sel_i,
    input  logic [NUM_SRC-1:0] nmi_sel_i,
    output logic               irq_o,
    output logic               nmi_o
);
    // OR reduction of the qualified sources.
    always_comb begin
        irq_o = |(status_i & enable_i & irq_sel_i);
        nmi_o = |(status_i & nmi_sel_i);
    end

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|(status_i & enable_i))); // R6
    AST_NMI_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |-> (|status_i)); // R7
endmodule

// File: rtl/priv_irq_ctrl.sv
// Module: priv_irq_ctrl (top)
// Interrupt status controller with per-source mask, IRQ/NMI routing,
// software preset and clear, raw trigger pass-through and per-source
// privilege protection. Read data is combinational from the address.
// Assumes one bus write per cycle and a synchronous active-low reset.
module priv_irq_ctrl
    import pic_pkg::*;
#(
    parameter int NUM_SRC = 49,
    parameter int DATA_W  = 32,
    localparam int WORDS  = (NUM_SRC + DATA_W - 1) / DATA_W,
    localparam int WSEL_W = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int ADDR_W = 3 + WSEL_W,
    localparam int PAD_W  = WORDS * DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr_i,
    input  logic               bus_priv_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    input  logic [NUM_SRC-1:0] hw_evt_i,
    output logic [NUM_SRC-1:0] raw_trig_o,
    output logic               irq_o,
    output logic               nmi_o
);
    pic_reg_e           reg_id;
    logic [WSEL_W-1:0]  word;
    logic               wr_enable, wr_preset, wr_clear;
    logic               wr_irqsel, wr_nmisel, wr_protect;
    logic [NUM_SRC-1:0] lane_mask, lane_data;
    logic [NUM_SRC-1:0] enable_q, irq_sel_q, nmi_sel_q, protect_q, status_q;
    logic [PAD_W-1:0]   rd_vec;

    pic_bus_decode #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .WSEL_W(WSEL_W)) u_decode (
        .wr_i        (bus_wr_i),
        .addr_i      (bus_addr_i),
        .wdata_i     (bus_wdata_i),
        .reg_id_o    (reg_id),
        .word_o      (word),
        .wr_enable_o (wr_enable),
        .wr_preset_o (wr_preset),
        .wr_clear_o  (wr_clear),
        .wr_irqsel_o (wr_irqsel),
        .wr_nmisel_o (wr_nmisel),
        .wr_protect_o(wr_protect),
        .lane_mask_o (lane_mask),
        .lane_data_o (lane_data)
    );

    pic_mask_reg #(.NUM_SRC(NUM_SRC), .PRIV_ONLY(1'b0)) u_enable (
        .clk(clk), .rst_n(rst_n), .wr_hit_i(wr_enable), .priv_i(bus_priv_i),
        .lane_mask_i(lane_mask), .lane_data_i(lane_data), .q_o(enable_q)
    );
    pic_mask_reg #(.NUM_SRC(NUM_SRC), .PRIV_ONLY(1'b1)) u_irq_sel (
        .clk(clk), .rst_n(rst_n), .wr_hit_i(wr_irqsel), .priv_i(bus_priv_i),
        .lane_mask_i(lane_mask), .lane_data_i(lane_data), .q_o(irq_sel_q)
    );
    pic_mask_reg #(.NUM_SRC(NUM_SRC), .PRIV_ONLY(1'b1)) u_nmi_sel (
        .clk(clk), .rst_n(rst_n), .wr_hit_i(wr_nmisel), .priv_i(bus_priv_i),
        .lane_mask_i(lane_mask), .lane_data_i(lane_data), .q_o(nmi_sel_q)
    );
    pic_mask_reg #(.NUM_SRC(NUM_SRC), .PRIV_ONLY(1'b1)) u_protect (
        .clk(clk), .rst_n(rst_n), .wr_hit_i(wr_protect), .priv_i(bus_priv_i),
        .lane_mask_i(lane_mask), .lane_data_i(lane_data), .q_o(protect_q)
    );

    pic_status_bank #(.NUM_SRC(NUM_SRC)) u_status (
        .clk(clk), .rst_n(rst_n), .evt_i(hw_evt_i),
        .set_i(wr_preset), .clr_i(wr_clear), .priv_i(bus_priv_i),
        .lane_mask_i(lane_mask), .lane_data_i(lane_data),
        .protect_i(protect_q), .status_o(status_q)
    );

    pic_irq_merge #(.NUM_SRC(NUM_SRC)) u_merge (
        .clk(clk), .rst_n(rst_n), .status_i(status_q), .enable_i(enable_q),
        .irq_sel_i(irq_sel_q), .nmi_sel_i(nmi_sel_q),
        .irq_o(irq_o), .nmi_o(nmi_o)
    );

    // Unmasked trigger pass-through.
    always_comb raw_trig_o = hw_evt_i;

    // Select the readable register, zero-padded to whole words.
    always_comb begin
        rd_vec = '0;
        unique case (reg_id)
            REG_ENABLE:  rd_vec[NUM_SRC-1:0] = enable_q;
            REG_STATUS:  rd_vec[NUM_SRC-1:0] = status_q;
            REG_IRQSEL:  rd_vec[NUM_SRC-1:0] = irq_sel_q;
            REG_NMISEL:  rd_vec[NUM_SRC-1:0] = nmi_sel_q;
            REG_PROTECT: rd_vec[NUM_SRC-1:0] = protect_q;
            default:     rd_vec = '0;
        endcase
    end

    // Word slice of the selected register.
    always_comb begin
        if (int'(word) < WORDS)
            bus_rdata_o = rd_vec[int'(word)*DATA_W +: DATA_W];
        else
            bus_rdata_o = '0;
    end

    AST_RAW_FOLLOWS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        raw_trig_o == hw_evt_i); // R8
    AST_STATUS_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && reg_id == REG_STATUS && hw_evt_i == '0) |=> (status_q & ~$past(status_q)) == '0); // R11
endmodule

// File: tb/priv_irq_ctrl_tb_top.sv
// Testbench for priv_irq_ctrl: a vector table walk, then directed tests.
module priv_irq_ctrl_tb_top;
    localparam int NS = 49;

    typedef struct packed {
        logic        rd;
        logic        priv;
        logic [3:0]  addr;
        logic [31:0] data;
        logic [7:0]  req;
    } vec_t;

    // Addresses: id*2 + word. 0/1 enable, 2/3 status, 4/5 preset,
    // 6/7 clear, 8/9 irq route, 10/11 nmi route, 12/13 protect.
    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 4'd0,  32'hA5A5_0000, 8'd10},
        '{1'b1, 1'b0, 4'd0,  32'hA5A5_0000, 8'd10},
        '{1'b0, 1'b0, 4'd8,  32'hFFFF_FFFF, 8'd10},
        '{1'b1, 1'b0, 4'd8,  32'h0000_0000, 8'd10},
        '{1'b0, 1'b1, 4'd8,  32'h0000_00FF, 8'd10},
        '{1'b1, 1'b0, 4'd8,  32'h0000_00FF, 8'd10},
        '{1'b0, 1'b1, 4'd9,  32'hFFFF_FFFF, 8'd11},
        '{1'b1, 1'b0, 4'd9,  32'h0001_FFFF, 8'd11},
        '{1'b0, 1'b0, 4'd4,  32'h0000_0011, 8'd3},
        '{1'b1, 1'b0, 4'd2,  32'h0000_0011, 8'd3},
        '{1'b0, 1'b0, 4'd5,  32'hFFFF_FFFF, 8'd3},
        '{1'b1, 1'b0, 4'd3,  32'h0001_FFFF, 8'd11},
        '{1'b0, 1'b0, 4'd6,  32'h0000_0001, 8'd4},
        '{1'b1, 1'b0, 4'd2,  32'h0000_0010, 8'd4},
        '{1'b0, 1'b0, 4'd7,  32'h0001_0000, 8'd4},
        '{1'b1, 1'b0, 4'd3,  32'h0000_FFFF, 8'd4},
        '{1'b0, 1'b1, 4'd12, 32'h0000_0010, 8'd9},
        '{1'b0, 1'b0, 4'd6,  32'h0000_0010, 8'd9},
        '{1'b1, 1'b0, 4'd2,  32'h0000_0010, 8'd9},
        '{1'b0, 1'b1, 4'd6,  32'h0000_0010, 8'd9},
        '{1'b1, 1'b0, 4'd2,  32'h0000_0000, 8'd9},
        '{1'b1, 1'b0, 4'd4,  32'h0000_0000, 8'd11}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_priv = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NS-1:0] hw_evt = '0;
    logic [NS-1:0] raw_trig;
    logic          irq, nmi;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    priv_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_priv_i(bus_priv),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .hw_evt_i(hw_evt), .raw_trig_o(raw_trig), .irq_o(irq), .nmi_o(nmi)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic priv, input logic [3:0] addr, input logic [31:0] data);
        @(negedge clk);
        bus_wr = 1'b1; bus_priv = priv; bus_addr = addr; bus_wdata = data;
        @(negedge clk);
        bus_wr = 1'b0; bus_priv = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] addr, output logic [31:0] data);
        @(negedge clk);
        bus_addr = addr;
        #1 data = bus_rdata;
    endtask

    task automatic read_check(input string req, input logic [3:0] addr, input logic [31:0] exp);
        logic [31:0] got;
        bus_read(addr, got);
        check(req, {32'h0, got}, {32'h0, exp});
    endtask

    initial begin
        logic [31:0] rd;
        // R1: reset state
        repeat (3) @(negedge clk);
        for (int a = 0; a < 16; a++) read_check("R1 reset read", 4'(a), 32'h0);
        check("R1 irq at reset", {63'h0, irq}, 64'h0);
        check("R1 nmi at reset", {63'h0, nmi}, 64'h0);
        @(negedge clk); rst_n = 1'b1;

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            if (VEC[v].rd) begin
                bus_read(VEC[v].addr, rd);
                check($sformatf("R%0d table step %0d", VEC[v].req, v), {32'h0, rd}, {32'h0, VEC[v].data});
            end else begin
                bus_write(VEC[v].priv, VEC[v].addr, VEC[v].data);
            end
        end
        // R11: status is read-only
        bus_write(1'b1, 4'd2, 32'hFFFF_FFFF);
        read_check("R11 status write ignored", 4'd2, 32'h0);
        read_check("R11 reg id 7 reads zero", 4'd14, 32'h0);
        // R6: status set and routed but not enabled in word 1
        check("R6 irq masked by enable", {63'h0, irq}, 64'h0);
        check("R7 nmi unrouted", {63'h0, nmi}, 64'h0);
        bus_write(1'b1, 4'd7, 32'hFFFF_FFFF);
        read_check("R4 clear word1", 4'd3, 32'h0);

        // R2/R8: event pulse on source 20
        @(negedge clk); hw_evt = NS'(1) << 20;
        #1 check("R8 raw trigger", 64'(raw_trig), 64'(NS'(1) << 20));
        @(negedge clk); hw_evt = '0;
        #1 check("R8 raw trigger idle", 64'(raw_trig), 64'h0);
        read_check("R2 event latched", 4'd2, 32'h0010_0000);
        repeat (3) @(negedge clk);
        read_check("R2 status sticky", 4'd2, 32'h0010_0000);

        // R6: irq needs enable and route
        bus_write(1'b0, 4'd0, 32'h0010_0000);
        bus_write(1'b1, 4'd8, 32'h0010_0000);
        #1 check("R6 irq asserted", {63'h0, irq}, 64'h1);
        bus_write(1'b0, 4'd0, 32'h0);
        #1 check("R6 irq off when disabled", {63'h0, irq}, 64'h0);
        // R7: nmi ignores enable
        bus_write(1'b1, 4'd10, 32'h0010_0000);
        #1 check("R7 nmi without enable", {63'h0, nmi}, 64'h1);
        bus_write(1'b0, 4'd10, 32'h0);
        #1 check("R10 user nmi route write ignored", {63'h0, nmi}, 64'h1);
        bus_write(1'b1, 4'd6, 32'h0010_0000);
        #1 check("R7 nmi drops on clear", {63'h0, nmi}, 64'h0);

        // R5: event and clear on source 40 (word 1 bit 8) in one cycle
        bus_write(1'b1, 4'd5, 32'h0000_0100);
        @(negedge clk);
        hw_evt = NS'(1) << 40;
        bus_wr = 1'b1; bus_priv = 1'b1; bus_addr = 4'd7; bus_wdata = 32'h0000_0100;
        @(negedge clk);
        hw_evt = '0; bus_wr = 1'b0; bus_priv = 1'b0;
        read_check("R5 event beats clear", 4'd3, 32'h0000_0100);
        bus_write(1'b1, 4'd7, 32'h0000_0100);
        read_check("R4 clear alone", 4'd3, 32'h0);
        bus_write(1'b0, 4'd4, 32'h0);
        read_check("R3 preset zero no effect", 4'd2, 32'h0);

        // R1: reset mid-run
        bus_write(1'b1, 4'd4, 32'h0000_0003);
        bus_write(1'b1, 4'd12, 32'h0000_0003);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int a = 0; a < 16; a++) read_check("R1 after reset", 4'(a), 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule